// File: doc/BRIEF.md
# Bridge Memory Window Decoder

This block holds the configuration state for two memory windows of a bus bridge that sits between a primary memory bus and a card-side bus. Each window is a page-aligned address range given by a lower and an upper page register. Software programs the windows through a small synchronous configuration port (dword offset, write strobe, byte lanes, write data, read data). The bridge presents a transaction address together with the side it came from, and the block answers in the same cycle with a hit flag, the index of the hit window, its prefetchable attribute, and whether the transaction should cross the bridge.

Both windows are decoded identically for the two directions. An address from the primary side that hits a window crosses to the card side. An address from the card side that misses both windows crosses to the primary side. Registers have 4-Kbyte granularity: only address bits 31:12 are stored, and the low 12 bits always read back as zero.

Top module: `memwin_decode`

## Requirements
- R1: Configuration dword offset 7 holds window 0 lower page, offset 8 window 0 upper page, offset 9 window 1 lower page, offset 10 window 1 upper page; each reads back through `cfg_rdata` in the same cycle as `cfg_addr` is presented.
- R2: A write stores bits 31:12 of `cfg_wdata` into the addressed register, lane by lane: `cfg_be[n]` enables bits 8n+7..8n, and a disabled lane keeps its old contents.
- R3: Bits 11:0 of every window register always read as zero; write data in those bits has no effect.
- R4: After reset all four window registers and both prefetch bits read as zero.
- R5: A window is enabled only when its lower or upper page register is nonzero; with both zero it never hits, so after reset address 0000_0000h misses.
- R6: An enabled window hits when address[31:12] is at least its lower page and at most its upper page; the upper page is inclusive through its last byte (xxxxxFFFh).
- R7: An enabled window whose lower page is greater than its upper page never hits.
- R8: `hit` is 1 when any window hits; `hit_win` gives the hit window (0 or 1), window 0 winning when both hit; with no hit, `hit_win` and `hit_pref` are 0.
- R9: Dword offset 15 bit 24 is the prefetchable attribute of window 0 and bit 25 that of window 1, written when `cfg_be[3]` is set; all other bits of that dword read zero; `hit_pref` reports the attribute of the window in `hit_win`.
- R10: With `txn_from_card` = 0, `fwd` equals `hit`; with `txn_from_card` = 1, `fwd` is 1 exactly when neither window hits.
- R11: Reads from any other offset return zero and writes to them change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 6 | Configuration dword offset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_be | input | 4 | Byte lane enables for writes |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| txn_addr | input | 32 | Transaction address to decode |
| txn_from_card | input | 1 | 1 when the address comes from the card side |
| hit | output | 1 | Address falls in an enabled window |
| hit_win | output | 1 | Index of the hit window |
| hit_pref | output | 1 | Prefetchable attribute of the hit window |
| fwd | output | 1 | Transaction should cross the bridge |

## Verification
The assertions assume that configuration and transaction inputs are known values, change only between clock edges, and that a write strobe lasts a single cycle with its offset and data held stable across the edge. The bench keeps within this by driving every input on the falling edge from tasks, pulsing the write strobe for exactly one cycle and sampling combinational outputs shortly after the inputs settle. Window contents seen by the decode checks are always those committed at the previous rising edge.

// File: rtl/memwin_decode.sv
module memwin_decode #(
  parameter int PG = 12,
  parameter int OW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [OW-1:0] cfg_addr,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_be,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic [31:0]   txn_addr,
  input  logic          txn_from_card,
  output logic          hit,
  output logic          hit_win,
  output logic          hit_pref,
  output logic          fwd
);
  localparam int AW = 32;
  localparam int HW = AW - PG;
  localparam logic [OW-1:0] OFF_B0 = OW'(7);
  localparam logic [OW-1:0] OFF_L0 = OW'(8);
  localparam logic [OW-1:0] OFF_B1 = OW'(9);
  localparam logic [OW-1:0] OFF_L1 = OW'(10);
  localparam logic [OW-1:0] OFF_BC = OW'(15);

  logic [1:0][HW-1:0] base_q, lim_q;
  logic [1:0]         pref_q, win_en, win_hit;
  logic [AW-1:0]      lane_m;
  logic [HW-1:0]      pg;
  logic               unused_bits;

  assign lane_m = {{8{cfg_be[3]}}, {8{cfg_be[2]}}, {8{cfg_be[1]}}, {8{cfg_be[0]}}};
  assign pg = txn_addr[AW-1:PG];
  assign unused_bits = &{1'b0, txn_addr[PG-1:0]};

  function automatic logic [HW-1:0] merge(input logic [HW-1:0] old);
    logic [AW-1:0] full;
    full = ({old, {PG{1'b0}}} & ~lane_m) | (cfg_wdata & lane_m);
    return full[AW-1:PG];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      lim_q  <= '0;
      pref_q <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        OFF_B0: base_q[0] <= merge(base_q[0]);
        OFF_L0: lim_q[0]  <= merge(lim_q[0]);
        OFF_B1: base_q[1] <= merge(base_q[1]);
        OFF_L1: lim_q[1]  <= merge(lim_q[1]);
        OFF_BC: if (cfg_be[3]) pref_q <= cfg_wdata[25:24];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cfg_addr)
      OFF_B0:  cfg_rdata = {base_q[0], {PG{1'b0}}};
      OFF_L0:  cfg_rdata = {lim_q[0],  {PG{1'b0}}};
      OFF_B1:  cfg_rdata = {base_q[1], {PG{1'b0}}};
      OFF_L1:  cfg_rdata = {lim_q[1],  {PG{1'b0}}};
      OFF_BC:  cfg_rdata = {6'd0, pref_q, 24'd0};
      default: cfg_rdata = '0;
    endcase
  end

  for (genvar w = 0; w < 2; w++) begin : g_win
    assign win_en[w]  = |{base_q[w], lim_q[w]};
    assign win_hit[w] = win_en[w] && (pg >= base_q[w]) && (pg <= lim_q[w]);
  end

  assign hit      = |win_hit;
  assign hit_win  = !win_hit[0] && win_hit[1];
  assign hit_pref = win_hit[0] ? pref_q[0] : (win_hit[1] && pref_q[1]);
  assign fwd      = txn_from_card ? !hit : hit;
endmodule

// File: rtl/memwin_decode_chk.sv
module memwin_decode_chk #(
  parameter int HW = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic [5:0]         cfg_addr,
  input logic               cfg_we,
  input logic [3:0]         cfg_be,
  input logic [HW-1:0]      wd_hi,
  input logic [11:0]        rd_lo,
  input logic [HW-1:0]      pg,
  input logic               txn_from_card,
  input logic               hit,
  input logic               hit_win,
  input logic               hit_pref,
  input logic               fwd,
  input logic [1:0][HW-1:0] base_q,
  input logic [1:0][HW-1:0] lim_q
);
  a_r3_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo == 12'd0);

  a_r2_full_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_be == 4'hF && cfg_addr == 6'd7 |=> base_q[0] == $past(wd_hi));

  a_r5_idle_nohit: assert property (@(posedge clk) disable iff (!rst_n)
    (base_q == '0 && lim_q == '0) |-> !hit);

  a_r6_win0_range: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !hit_win |-> pg >= base_q[0] && pg <= lim_q[0]);

  a_r6_win1_range: assert property (@(posedge clk) disable iff (!rst_n)
    hit && hit_win |-> pg >= base_q[1] && pg <= lim_q[1]);

  a_r8_nohit_clean: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> !hit_win && !hit_pref);

  a_r10_direction: assert property (@(posedge clk) disable iff (!rst_n)
    fwd == (hit != txn_from_card));
endmodule

bind memwin_decode memwin_decode_chk #(.HW(HW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_we(cfg_we), .cfg_be(cfg_be),
  .wd_hi(cfg_wdata[31:12]), .rd_lo(cfg_rdata[11:0]), .pg(pg),
  .txn_from_card(txn_from_card), .hit(hit), .hit_win(hit_win), .hit_pref(hit_pref),
  .fwd(fwd), .base_q(base_q), .lim_q(lim_q)
);

// File: tb/memwin_decode_tb.sv
module memwin_decode_tb;
  logic        clk = 0, rst_n = 0;
  logic [5:0]  cfg_addr = '0;
  logic        cfg_we = 0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata, txn_addr = '0;
  logic        txn_from_card = 0, hit, hit_win, hit_pref, fwd;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  memwin_decode u_dut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int off, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    cfg_addr = 6'(off); cfg_be = be; cfg_wdata = d; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0; cfg_be = '0;
  endtask

  task automatic rd(int off, output logic [31:0] d);
    cfg_addr = 6'(off);
    #1 d = cfg_rdata;
  endtask

  task automatic look(logic [31:0] a, logic card, output logic [3:0] r);
    txn_addr = a; txn_from_card = card;
    #1 r = {hit, hit_win, hit_pref, fwd};
  endtask

  task automatic clear_all();
    for (int o = 7; o <= 10; o++) wr(o, 4'hF, 32'h0);
    wr(15, 4'hF, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d; logic [3:0] r;
    for (int o = 7; o <= 10; o++) begin rd(o, d); check("R4 reg zero", d, 0); end
    rd(15, d); check("R4 pref zero", d, 0);
    look(32'h0, 0, r); check("R5 reset miss primary", 32'(r), 32'h0);
    look(32'h0, 1, r); check("R5 reset miss card fwd", 32'(r), 32'h1);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    clear_all();
    wr(7, 4'hF, 32'hFFFF_FFFF); rd(7, d); check("R1 R3 base0", d, 32'hFFFF_F000);
    wr(9, 4'hF, 32'hAAAA_A123); rd(9, d); check("R1 R3 base1", d, 32'hAAAA_A000);
    wr(10, 4'hF, 32'h5555_5FFF); rd(10, d); check("R1 lim1", d, 32'h5555_5000);
    wr(8, 4'b0010, 32'h1234_5678); rd(8, d); check("R2 lane1 only", d, 32'h0000_5000);
    wr(8, 4'b1000, 32'h9ABC_DEF0); rd(8, d); check("R2 lane3 keeps rest", d, 32'h9A00_5000);
    wr(7, 4'b0001, 32'h0000_0000); rd(7, d); check("R3 lane0 no effect", d, 32'hFFFF_F000);
    wr(11, 4'hF, 32'hFFFF_FFFF); rd(11, d); check("R11 unmapped read", d, 0);
    rd(7, d); check("R11 base0 untouched", d, 32'hFFFF_F000);
    rd(15, d); check("R11 pref untouched", d, 0);
  endtask

  task automatic t_range();
    logic [3:0] r;
    clear_all();
    wr(7, 4'hF, 32'h1000_0000); wr(8, 4'hF, 32'h1000_F000);
    look(32'h0FFF_FFFF, 0, r); check("R6 below", 32'(r[3]), 0);
    look(32'h1000_0000, 0, r); check("R6 base edge", 32'(r[3]), 1);
    look(32'h1000_FFFF, 0, r); check("R6 limit page end", 32'(r[3]), 1);
    look(32'h1001_0000, 0, r); check("R6 above", 32'(r[3]), 0);
  endtask

  task automatic t_enable();
    logic [3:0] r;
    clear_all();
    look(32'h0000_0ABC, 0, r); check("R5 disabled", 32'(r[3]), 0);
    wr(8, 4'hF, 32'h0000_1000);
    look(32'h0000_0ABC, 0, r); check("R5 enabled by limit", 32'(r[3]), 1);
  endtask

  task automatic t_inverted();
    logic [3:0] r;
    clear_all();
    wr(9, 4'hF, 32'h2000_0000); wr(10, 4'hF, 32'h1000_0000);
    look(32'h1800_0000, 0, r); check("R7 inverted mid", 32'(r[3]), 0);
    look(32'h2000_0000, 0, r); check("R7 inverted base", 32'(r[3]), 0);
  endtask

  task automatic t_priority();
    logic [3:0] r; logic [31:0] d;
    clear_all();
    wr(7, 4'hF, 32'h4000_0000); wr(8, 4'hF, 32'h4000_3000);
    wr(9, 4'hF, 32'h4000_2000); wr(10, 4'hF, 32'h4000_8000);
    wr(15, 4'b1000, 32'h0200_0000);
    rd(15, d); check("R9 pref readback", d, 32'h0200_0000);
    wr(15, 4'b0111, 32'hFFFF_FFFF);
    rd(15, d); check("R9 lane3 gates pref", d, 32'h0200_0000);
    look(32'h4000_2500, 0, r); check("R8 overlap win0", 32'(r), 32'b1001);
    look(32'h4000_5000, 0, r); check("R9 win1 pref", 32'(r), 32'b1111);
    look(32'h4000_0000, 0, r); check("R8 win0 only", 32'(r), 32'b1001);
    wr(15, 4'b1000, 32'h0100_0000);
    look(32'h4000_0000, 0, r); check("R9 win0 pref", 32'(r), 32'b1011);
  endtask

  task automatic t_direction();
    logic [3:0] r;
    look(32'h4000_1000, 1, r); check("R10 card hit stays", 32'(r[0]), 0);
    look(32'h7000_0000, 1, r); check("R10 card miss crosses", 32'(r[0]), 1);
    look(32'h7000_0000, 0, r); check("R10 primary miss stays", 32'(r[0]), 0);
    look(32'h4000_1000, 0, r); check("R10 primary hit crosses", 32'(r[0]), 1);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_range();
    t_enable();
    t_inverted();
    t_priority();
    t_direction();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule